// File: doc/BRIEF.md
# Compressed L3 Header Parser

This block reads a compressed, IPv6-derived network-layer header from the first bytes of an Ethernet payload. The payload arrives one byte per accepted cycle. The header has no version field and no payload-length field. It carries the traffic class, a 4-bit hop limit, the 20-bit flow label and the next-header value. It also carries two 4-bit codes that set the lengths of the source and destination addresses, and the two addresses follow directly after these codes.

The parser decodes both codes into byte counts. It gathers each address into a right-aligned 128-bit value with zeros in the unused high bytes. It computes the header length rounded up to a 4-byte boundary and takes the payload length as the frame length minus that header length. Results are published with a one-cycle `hdr_valid` pulse. A frame that is too short for its own header produces a one-cycle `hdr_err` pulse instead. The user supplies the L2 payload length on `frame_len` together with the first byte of each frame.

Top module: `l3c_hdr_parser`

## Requirements
- R1: After reset, `hdr_valid` and `hdr_err` are both low, and they stay low until a frame is received.
- R2: Byte 0 of the frame is the traffic class. Byte 1 bits 7:4 are the hop limit. Byte 1 bits 3:0, byte 2 and byte 3 together form the flow label, most significant part first.
- R3: Byte 4 is the next-header value. Byte 5 bits 7:4 are the source length code and byte 5 bits 3:0 are the destination length code.
- R4: A nonzero code N gives an address of N bytes. Code 0 gives a 16-byte address. The decoded counts appear on `src_bytes` and `dst_bytes`.
- R5: The source address starts at byte 6 and the destination address follows it directly. Each address is output right-aligned, first byte most significant, with zeros above it.
- R6: `hdr_len` equals (6 + source bytes + destination bytes) rounded up to a multiple of 4. Codes 1/1 give 8, codes 0/0 give 40, and codes 4/0 give 28.
- R7: `payload_len` equals `frame_len` minus `hdr_len`.
- R8: Pad bytes between the end of the destination address and `hdr_len` have no effect on any output.
- R9: If `frame_len` is smaller than `hdr_len`, `hdr_err` pulses for one cycle in the cycle after byte 5 is accepted. No `hdr_valid` is produced for that frame.
- R10: If `in_last` arrives on a byte before byte 5 is reached, `hdr_err` pulses for one cycle in the cycle after that byte, and no `hdr_valid` is produced.
- R11: `hdr_valid` is high for exactly one cycle: the cycle after the byte at index `hdr_len`-1 is accepted. Idle cycles with `in_valid` low only stall parsing.
- R12: A byte with `in_sof` high restarts parsing at byte 0 at any time. The aborted frame produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_sof | input | 1 | Accepted byte is byte 0 of a frame |
| in_last | input | 1 | Accepted byte is the final byte of the frame |
| in_data | input | 8 | Payload byte |
| frame_len | input | 16 | L2 payload length in bytes, sampled with the first byte |
| hdr_valid | output | 1 | One-cycle pulse: header fields are valid |
| hdr_err | output | 1 | One-cycle pulse: frame truncated |
| traffic_class | output | 8 | Traffic class |
| hop_limit | output | 4 | Hop limit |
| flow_label | output | 20 | Flow label |
| next_hdr | output | 8 | Next-header value |
| src_code | output | 4 | Source length code |
| dst_code | output | 4 | Destination length code |
| src_bytes | output | 5 | Decoded source address byte count |
| dst_bytes | output | 5 | Decoded destination address byte count |
| src_addr | output | 128 | Source address, right-aligned |
| dst_addr | output | 128 | Destination address, right-aligned |
| hdr_len | output | 6 | Padded header length in bytes |
| payload_len | output | 16 | Frame length minus header length |

## Verification
The state that can go wrong is the byte index together with the lengths latched at byte 5. A stale or off-by-one index makes bytes land in the wrong field or the wrong address. It also makes `hdr_valid` fire a cycle early or late, and both effects show at the first pulse of the frame. Wrong length arithmetic shows up at once as a bad `hdr_len` or `payload_len`, or as a missing or spurious `hdr_err` in the cycle after byte 5. The stimulus covers every code value, includes idle gaps, and uses pad bytes with nonzero contents so that address corruption cannot hide behind zeros.

// File: rtl/l3c_pkg.sv
package l3c_pkg;
  localparam int CODE_W         = 4;
  localparam int MAX_ADDR_BYTES = 16;
  localparam int CNT_W          = $clog2(MAX_ADDR_BYTES + 1);
  localparam int FIXED_BYTES    = 6;
  localparam int HL_W           = 6;

  typedef enum logic [0:0] {ST_IDLE, ST_HDR} pstate_e;

  // code 0 selects a full 16-byte address, otherwise the code is the byte count
  function automatic logic [CNT_W-1:0] code_bytes(input logic [CODE_W-1:0] c);
    return (c == '0) ? CNT_W'(MAX_ADDR_BYTES) : CNT_W'(c);
  endfunction
endpackage

// File: rtl/l3c_len_calc.sv
module l3c_len_calc
  import l3c_pkg::*;
(
  input  logic [CODE_W-1:0] src_code,
  input  logic [CODE_W-1:0] dst_code,
  output logic [CNT_W-1:0]  src_bytes,
  output logic [CNT_W-1:0]  dst_bytes,
  output logic [HL_W-1:0]   hdr_len
);
  localparam int SUM_W = HL_W + 1;
  logic [SUM_W-1:0] raw_len;
  logic [SUM_W-1:0] rounded;

  always_comb begin
    src_bytes = code_bytes(src_code);
    dst_bytes = code_bytes(dst_code);
    raw_len   = SUM_W'(FIXED_BYTES) + SUM_W'(src_bytes) + SUM_W'(dst_bytes);
    rounded   = (raw_len + SUM_W'(3)) & ~SUM_W'(3);
    hdr_len   = rounded[HL_W-1:0];
  end
endmodule

// File: rtl/l3c_addr_acc.sv
module l3c_addr_acc #(
  parameter int ADDR_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (clr)           addr_d = '0;
    else if (shift_en) addr_d = {addr[ADDR_W-9:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end
endmodule

// File: rtl/l3c_hdr_parser.sv
module l3c_hdr_parser
  import l3c_pkg::*;
#(
  parameter int ADDR_W = 128,
  parameter int FLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  input  logic [FLEN_W-1:0] frame_len,
  output logic              hdr_valid,
  output logic              hdr_err,
  output logic [7:0]        traffic_class,
  output logic [3:0]        hop_limit,
  output logic [19:0]       flow_label,
  output logic [7:0]        next_hdr,
  output logic [CODE_W-1:0] src_code,
  output logic [CODE_W-1:0] dst_code,
  output logic [CNT_W-1:0]  src_bytes,
  output logic [CNT_W-1:0]  dst_bytes,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [HL_W-1:0]   hdr_len,
  output logic [FLEN_W-1:0] payload_len
);
  localparam int LIM_W = HL_W + 1;
  localparam logic [HL_W-1:0] CODE_IDX = HL_W'(FIXED_BYTES - 1);

  pstate_e           state, state_d;
  logic [HL_W-1:0]   idx, idx_d;
  logic [FLEN_W-1:0] flen_r, flen_d;
  logic [7:0]        tc_d, nh_d;
  logic [3:0]        hop_d;
  logic [19:0]       flow_d;
  logic [CODE_W-1:0] sc_d, dc_d;
  logic [CNT_W-1:0]  sb_d, db_d;
  logic [HL_W-1:0]   hl_d;
  logic [FLEN_W-1:0] pl_d;
  logic              valid_d, err_d;

  logic [CNT_W-1:0]  lc_sb, lc_db;
  logic [HL_W-1:0]   lc_hl;

  l3c_len_calc u_len (
    .src_code (in_data[7:4]),
    .dst_code (in_data[3:0]),
    .src_bytes(lc_sb),
    .dst_bytes(lc_db),
    .hdr_len  (lc_hl)
  );

  logic              body_byte;
  logic [LIM_W-1:0]  src_end, dst_end;
  logic              acc_en [2];
  logic [ADDR_W-1:0] acc_q  [2];
  logic              start;

  always_comb begin
    start     = in_valid && in_sof;
    body_byte = in_valid && !in_sof && (state == ST_HDR) && (idx >= HL_W'(FIXED_BYTES));
    src_end   = LIM_W'(FIXED_BYTES) + LIM_W'(src_bytes);
    dst_end   = src_end + LIM_W'(dst_bytes);
    acc_en[0] = body_byte && (LIM_W'(idx) < src_end);
    acc_en[1] = body_byte && (LIM_W'(idx) >= src_end) && (LIM_W'(idx) < dst_end);
  end

  for (genvar g = 0; g < 2; g++) begin : g_addr
    l3c_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .shift_en(acc_en[g]),
      .din     (in_data),
      .addr    (acc_q[g])
    );
  end

  assign src_addr = acc_q[0];
  assign dst_addr = acc_q[1];

  always_comb begin
    state_d = state;   idx_d  = idx;        flen_d = flen_r;
    tc_d    = traffic_class; hop_d = hop_limit; flow_d = flow_label;
    nh_d    = next_hdr; sc_d  = src_code;   dc_d   = dst_code;
    sb_d    = src_bytes; db_d = dst_bytes;  hl_d   = hdr_len;
    pl_d    = payload_len;
    valid_d = 1'b0;    err_d  = 1'b0;
    if (start) begin
      tc_d   = in_data;
      idx_d  = HL_W'(1);
      flen_d = frame_len;
      if (in_last) begin
        err_d   = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = ST_HDR;
      end
    end else if (in_valid && state == ST_HDR) begin
      idx_d = idx + HL_W'(1);
      case (idx)
        HL_W'(1): begin hop_d = in_data[7:4]; flow_d[19:16] = in_data[3:0]; end
        HL_W'(2): flow_d[15:8] = in_data;
        HL_W'(3): flow_d[7:0]  = in_data;
        HL_W'(4): nh_d = in_data;
        CODE_IDX: begin
          sc_d = in_data[7:4]; dc_d = in_data[3:0];
          sb_d = lc_sb; db_d = lc_db; hl_d = lc_hl;
          pl_d = flen_r - FLEN_W'(lc_hl);
        end
        default: ;
      endcase
      if (idx == CODE_IDX) begin
        if (flen_r < FLEN_W'(lc_hl) || in_last) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end else if (idx > CODE_IDX && idx == hdr_len - HL_W'(1)) begin
        valid_d = 1'b1;
        state_d = ST_IDLE;
      end else if (in_last) begin
        err_d   = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; idx <= '0; flen_r <= '0;
      traffic_class <= '0; hop_limit <= '0; flow_label <= '0; next_hdr <= '0;
      src_code <= '0; dst_code <= '0; src_bytes <= '0; dst_bytes <= '0;
      hdr_len <= '0; payload_len <= '0; hdr_valid <= 1'b0; hdr_err <= 1'b0;
    end else begin
      state <= state_d; idx <= idx_d; flen_r <= flen_d;
      traffic_class <= tc_d; hop_limit <= hop_d; flow_label <= flow_d; next_hdr <= nh_d;
      src_code <= sc_d; dst_code <= dc_d; src_bytes <= sb_d; dst_bytes <= db_d;
      hdr_len <= hl_d; payload_len <= pl_d; hdr_valid <= valid_d; hdr_err <= err_d;
    end
  end

  // R9: a frame either completes or fails, never both in one cycle
  p_valid_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && hdr_err));

  // R11: a result only follows an accepted byte
  p_valid_after_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> $past(in_valid));

  // R11: the valid strobe lasts a single cycle
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R6: padded length lies within the legal range and on a 4-byte boundary
  p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (hdr_len >= HL_W'(8) && hdr_len <= HL_W'(40) && hdr_len[1:0] == 2'b00));

  // R6: padding adds fewer than four bytes to the address-bearing header
  p_len_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (LIM_W'(hdr_len) >= dst_end && LIM_W'(hdr_len) < dst_end + LIM_W'(4)));

  // R4: decoded counts are between one and sixteen bytes
  p_bytes_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (src_bytes != '0 && src_bytes <= CNT_W'(MAX_ADDR_BYTES)
                   && dst_bytes != '0 && dst_bytes <= CNT_W'(MAX_ADDR_BYTES)));

  // R7: payload plus header accounts for the whole frame
  p_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (payload_len + FLEN_W'(hdr_len) == flen_r));
endmodule

// File: tb/l3c_hdr_parser_tb.sv
module l3c_hdr_parser_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_last;
  logic [7:0] in_data;
  logic [15:0] frame_len;
  logic hdr_valid, hdr_err;
  logic [7:0] traffic_class, next_hdr;
  logic [3:0] hop_limit, src_code, dst_code;
  logic [19:0] flow_label;
  logic [4:0] src_bytes, dst_bytes;
  logic [127:0] src_addr, dst_addr;
  logic [5:0] hdr_len;
  logic [15:0] payload_len;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;
  logic [7:0] fb [0:63];

  always #4 clk = ~clk;

  l3c_hdr_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_last(in_last), .in_data(in_data), .frame_len(frame_len),
    .hdr_valid(hdr_valid), .hdr_err(hdr_err), .traffic_class(traffic_class),
    .hop_limit(hop_limit), .flow_label(flow_label), .next_hdr(next_hdr),
    .src_code(src_code), .dst_code(dst_code), .src_bytes(src_bytes),
    .dst_bytes(dst_bytes), .src_addr(src_addr), .dst_addr(dst_addr),
    .hdr_len(hdr_len), .payload_len(payload_len)
  );

  function automatic int cbytes(input logic [3:0] c);
    return (c == 0) ? 16 : int'(c);
  endfunction

  function automatic int padlen(input logic [3:0] s, input logic [3:0] d);
    int x = 6 + cbytes(s) + cbytes(d);
    return (x + 3) & ~3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  // sends nsend bytes of a frame of flen bytes whose header uses codes sc/dc
  task automatic run_frame(input logic [3:0] sc, input logic [3:0] dc,
                           input int flen, input int nsend, input bit gaps);
    int hl = padlen(sc, dc);
    int sb = cbytes(sc);
    int db = cbytes(dc);
    logic [127:0] es = '0;
    logic [127:0] ed = '0;
    for (int i = 0; i < 64; i++) fb[i] = 8'($urandom);
    fb[5] = {sc, dc};
    for (int i = 0; i < sb; i++) es = {es[119:0], fb[6+i]};
    for (int i = 0; i < db; i++) ed = {ed[119:0], fb[6+sb+i]};
    for (int k = 0; k < nsend; k++) begin
      bit ev, ee;
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int j = 0; j < g; j++) begin
          in_valid = 0; in_sof = 0; in_last = 0;
          @(negedge clk);
          chk({hdr_valid, hdr_err} == 2'b00, "R11 idle gap quiet", {hdr_valid, hdr_err}, 0);
        end
      end
      in_valid = 1; in_sof = (k == 0); in_last = (k == flen - 1);
      in_data = fb[k]; frame_len = 16'(flen);
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_last = 0;
      ee = 0; ev = 0;
      if (k <= 5 && k == flen - 1) ee = 1;
      else if (k == 5 && flen < hl) ee = 1;
      else if (flen >= hl && k == hl - 1) ev = 1;
      chk({hdr_valid, hdr_err} == {ev, ee}, "R9,R10,R11,R12 strobes",
          {hdr_valid, hdr_err}, {ev, ee});
      if (ev) begin
        chk(traffic_class == fb[0], "R2 traffic class", traffic_class, fb[0]);
        chk(hop_limit == fb[1][7:4], "R2 hop limit", hop_limit, fb[1][7:4]);
        chk(flow_label == {fb[1][3:0], fb[2], fb[3]}, "R2 flow label", flow_label,
            {fb[1][3:0], fb[2], fb[3]});
        chk(next_hdr == fb[4], "R3 next header", next_hdr, fb[4]);
        chk({src_code, dst_code} == fb[5], "R3 codes", {src_code, dst_code}, fb[5]);
        chk(src_bytes == 5'(sb) && dst_bytes == 5'(db), "R4 byte counts",
            {src_bytes, dst_bytes}, {5'(sb), 5'(db)});
        chk(src_addr == es, "R5,R8 source address", src_addr, es);
        chk(dst_addr == ed, "R5,R8 destination address", dst_addr, ed);
        chk(hdr_len == 6'(hl), "R6 header length", hdr_len, hl);
        chk(payload_len == 16'(flen - hl), "R7 payload length", payload_len, flen - hl);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 0; in_valid = 0; in_sof = 0; in_last = 0; in_data = 0; frame_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hdr_valid == 0, "R1 reset valid", hdr_valid, 0);
    chk(hdr_err == 0, "R1 reset err", hdr_err, 0);

    run_frame(4'd1, 4'd1, 8, 8, 0);    // R6 8-byte header, empty payload
    run_frame(4'd0, 4'd0, 44, 44, 0);  // R6 full addresses, 40 bytes
    run_frame(4'd2, 4'd2, 20, 20, 1);  // R6 12 bytes
    run_frame(4'd4, 4'd0, 30, 30, 0);  // R6 28 bytes
    run_frame(4'd15, 4'd15, 36, 36, 0);
    run_frame(4'd3, 4'd1, 16, 16, 0);  // R8 two pad bytes
    run_frame(4'd0, 4'd0, 20, 20, 0);  // R9 frame shorter than header
    run_frame(4'd1, 4'd1, 6, 6, 0);    // R9 ends at code byte
    run_frame(4'd1, 4'd1, 3, 3, 0);    // R10 ends early
    run_frame(4'd1, 4'd1, 1, 1, 0);    // R10 single byte
    run_frame(4'd2, 4'd3, 30, 3, 0);   // R12 aborted frame
    run_frame(4'd5, 4'd7, 24, 24, 0);  // R12 restart parses cleanly

    for (int n = 0; n < 400; n++) begin
      logic [3:0] sc = 4'($urandom_range(0, 15));
      logic [3:0] dc = 4'($urandom_range(0, 15));
      int hl = padlen(sc, dc);
      int fl = ($urandom_range(0, 9) == 0) ? $urandom_range(1, hl - 1)
                                             : hl + $urandom_range(0, 8);
      run_frame(sc, dc, fl, fl, 1);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule